// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block translates a 32-bit virtual address into a physical address. It reads a directory entry and, for a normal page, a second-level table entry. All reads and writes go through a single memory port that allows one access in flight at a time. Both levels are checked for permission, and the walk sets the accessed and dirty bits in the final (leaf) entry when they need updating. When paging is disabled the address passes through unchanged, with no memory traffic.

A request is offered with `req_valid` while `req_ready` is high. The walker answers with a one-cycle `resp_valid` pulse that carries either a physical address or a fault flag. A fault on this port is what the surrounding core turns into its page-fault exception. Walk states: `ST_IDLE` (waiting), `ST_DIR` (directory read), `ST_TBL` (table read), `ST_WB` (leaf write-back), `ST_RESP` (answer pulse). Transitions:
- `ST_IDLE` goes to `ST_RESP` on a request with paging off, and to `ST_DIR` on a request with paging on.
- `ST_DIR` goes to `ST_RESP` on a fault, to `ST_WB` or `ST_RESP` for a large page, and to `ST_TBL` otherwise.
- `ST_TBL` goes to `ST_RESP` on a fault, and to `ST_WB` or `ST_RESP` on success.
- `ST_WB` goes to `ST_RESP` on acknowledge.
- `ST_RESP` always goes to `ST_IDLE`.

Top module: `pt_walker`

## Requirements
- R1: With `pg_enable` low at acceptance, `resp_valid` rises in the cycle after acceptance with `resp_paddr` equal to the virtual address, `resp_fault` low and no memory access.
- R2: The first read goes to byte address {`dir_base`[31:12], va[31:22], 2'b00}. For a normal page, the second read goes to {dir_entry[31:12], va[21:12], 2'b00}.
- R3: For a normal page (dir_entry bit 7 = 0) that passes, `resp_paddr` = {table_entry[31:12], va[11:0]}, after exactly two reads.
- R4: A directory entry with bit 7 = 1 is a 4 MB page. `resp_paddr` = {dir_entry[31:22], va[21:0]}, after exactly one read.
- R5: An entry with bit 0 (present) = 0 at either level faults at once. A fault gives `resp_fault` high, `resp_paddr` zero and no write.
- R6: A user request (`req_user` = 1) that meets an entry with bit 2 (user) = 0 at either level faults.
- R7: A write request (`req_write` = 1) that meets an entry with bit 1 (read/write) = 0 at either level faults.
- R8: After a successful walk, the leaf entry is written back to its own address when needed. This happens when bit 3 (accessed) is 0, or when the request is a write and bit 4 (dirty) is 0. The written value is the entry with bit 3 set, and with bit 4 also set on a write. Otherwise there is no write.
- R9: `mem_req` stays high with stable address, direction and write data until `mem_ack`, and each access is issued exactly once.
- R10: `req_ready` is low from acceptance until the response. `req_valid` during that time is ignored.
- R11: Each accepted request yields exactly one single-cycle `resp_valid` pulse.
- R12: After reset, `req_ready` is high and `mem_req` and `resp_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle, request accepted |
| req_vaddr | input | 32 | Virtual address |
| req_write | input | 1 | Request is a store |
| req_user | input | 1 | Request comes from user mode |
| pg_enable | input | 1 | Paging enabled |
| dir_base | input | 32 | Directory base register (bits 31:12 used) |
| resp_valid | output | 1 | Result pulse |
| resp_paddr | output | 32 | Physical address (zero on fault) |
| resp_fault | output | 1 | Page fault |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Byte address of the entry |
| mem_wdata | output | 32 | Write-back data |
| mem_ack | input | 1 | Access complete (read data valid) |
| mem_rdata | input | 32 | Read data |

## Verification
Every cycle, the assertions check the following port-level rules:
- the memory request stays stable while it waits for acknowledge;
- the pass-through answer follows acceptance by one cycle;
- responses are single pulses;
- the walker is never ready while it holds the memory port;
- a fault carries a zero address;
- a write-back always sets the accessed bit.

Only the bench's sweeps can show the rest, because each result depends on memory contents:
- the permission sweep over both entry levels, request kinds and accessed/dirty states;
- the exact read addresses and read counts;
- the translated addresses for both page sizes;
- the write-back values;
- that a request offered while busy is ignored.

// File: rtl/pt_walk_pkg.sv
package pt_walk_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DIR,
        ST_TBL,
        ST_WB,
        ST_RESP
    } walk_st_e;

    localparam int ENT_PRESENT = 0;
    localparam int ENT_WRITE   = 1;
    localparam int ENT_USER    = 2;
    localparam int ENT_ACC     = 3;
    localparam int ENT_DIRTY   = 4;
    localparam int ENT_LARGE   = 7;
endpackage

// File: rtl/pte_check.sv
module pte_check
    import pt_walk_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [AW-1:0] entry,
    input  logic          is_write,
    input  logic          is_user,
    output logic          allow,
    output logic          wb_need,
    output logic [AW-1:0] wb_data
);
    always_comb begin
        allow = entry[ENT_PRESENT]
              && !(is_user  && !entry[ENT_USER])
              && !(is_write && !entry[ENT_WRITE]);
        wb_need = !entry[ENT_ACC] || (is_write && !entry[ENT_DIRTY]);
        wb_data = entry;
        wb_data[ENT_ACC] = 1'b1;
        if (is_write) begin
            wb_data[ENT_DIRTY] = 1'b1;
        end
    end
endmodule

// File: rtl/pa_compose.sv
module pa_compose #(
    parameter int AW    = 32,
    parameter int OFF_W = 12
) (
    input  logic [AW-1:0] dir_base,
    input  logic [AW-1:0] vaddr,
    input  logic [AW-1:0] entry,
    output logic [AW-1:0] dir_addr,
    output logic [AW-1:0] tbl_addr,
    output logic [AW-1:0] pa_small,
    output logic [AW-1:0] pa_large
);
    localparam int TIDX_W = OFF_W - 2;
    localparam int DIDX_W = AW - OFF_W - TIDX_W;
    localparam int LOFF_W = OFF_W + TIDX_W;

    always_comb begin
        dir_addr = {dir_base[AW-1:OFF_W], vaddr[AW-1 -: DIDX_W], 2'b00};
        tbl_addr = {entry[AW-1:OFF_W], vaddr[LOFF_W-1 -: TIDX_W], 2'b00};
        pa_small = {entry[AW-1:OFF_W], vaddr[OFF_W-1:0]};
        pa_large = {entry[AW-1:LOFF_W], vaddr[LOFF_W-1:0]};
    end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import pt_walk_pkg::*;
#(
    parameter int AW    = 32,
    parameter int OFF_W = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [AW-1:0] req_vaddr,
    input  logic          req_write,
    input  logic          req_user,
    input  logic          pg_enable,
    input  logic [AW-1:0] dir_base,
    output logic          resp_valid,
    output logic [AW-1:0] resp_paddr,
    output logic          resp_fault,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [AW-1:0] mem_wdata,
    input  logic          mem_ack,
    input  logic [AW-1:0] mem_rdata
);
    walk_st_e      st;
    logic [AW-1:0] va_q, cur_addr_q, pa_q, wb_q;
    logic          wr_q, usr_q, flt_q;

    logic [AW-1:0] va_sel;
    logic [AW-1:0] dir_addr, tbl_addr, pa_small, pa_large, wb_data;
    logic          allow, wb_need;

    assign va_sel = (st == ST_IDLE) ? req_vaddr : va_q;

    pa_compose #(.AW(AW), .OFF_W(OFF_W)) compose_i (
        .dir_base (dir_base),
        .vaddr    (va_sel),
        .entry    (mem_rdata),
        .dir_addr (dir_addr),
        .tbl_addr (tbl_addr),
        .pa_small (pa_small),
        .pa_large (pa_large)
    );

    pte_check #(.AW(AW)) check_i (
        .entry    (mem_rdata),
        .is_write (wr_q),
        .is_user  (usr_q),
        .allow    (allow),
        .wb_need  (wb_need),
        .wb_data  (wb_data)
    );

    // State register and walk bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= ST_IDLE;
            va_q       <= '0;
            cur_addr_q <= '0;
            pa_q       <= '0;
            wb_q       <= '0;
            wr_q       <= 1'b0;
            usr_q      <= 1'b0;
            flt_q      <= 1'b0;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    if (req_valid) begin
                        va_q       <= req_vaddr;
                        wr_q       <= req_write;
                        usr_q      <= req_user;
                        flt_q      <= 1'b0;
                        cur_addr_q <= dir_addr;
                        if (!pg_enable) begin
                            pa_q <= req_vaddr;
                            st   <= ST_RESP;
                        end else begin
                            st <= ST_DIR;
                        end
                    end
                end
                ST_DIR: begin
                    if (mem_ack) begin
                        if (!allow) begin
                            flt_q <= 1'b1;
                            pa_q  <= '0;
                            st    <= ST_RESP;
                        end else if (mem_rdata[ENT_LARGE]) begin
                            pa_q <= pa_large;
                            wb_q <= wb_data;
                            st   <= wb_need ? ST_WB : ST_RESP;
                        end else begin
                            cur_addr_q <= tbl_addr;
                            st         <= ST_TBL;
                        end
                    end
                end
                ST_TBL: begin
                    if (mem_ack) begin
                        if (!allow) begin
                            flt_q <= 1'b1;
                            pa_q  <= '0;
                            st    <= ST_RESP;
                        end else begin
                            pa_q <= pa_small;
                            wb_q <= wb_data;
                            st   <= wb_need ? ST_WB : ST_RESP;
                        end
                    end
                end
                ST_WB: begin
                    if (mem_ack) begin
                        st <= ST_RESP;
                    end
                end
                ST_RESP: st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Outputs decoded from state
    always_comb begin
        req_ready  = (st == ST_IDLE);
        mem_req    = (st == ST_DIR) || (st == ST_TBL) || (st == ST_WB);
        mem_we     = (st == ST_WB);
        mem_addr   = cur_addr_q;
        mem_wdata  = (st == ST_WB) ? wb_q : '0;
        resp_valid = (st == ST_RESP);
        resp_paddr = pa_q;
        resp_fault = flt_q;
    end

    assert_hold_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)
                                   && $stable(mem_we) && $stable(mem_wdata)));

    assert_bypass_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !pg_enable) |=>
            (resp_valid && !resp_fault && !mem_req && resp_paddr == $past(req_vaddr)));

    assert_single_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);

    assert_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !req_ready);

    assert_fault_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_fault) |-> (resp_paddr == '0));

    assert_wb_acc_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_req && mem_wdata[ENT_ACC]));
endmodule

// File: tb/pt_walker_tb_top.sv
module pt_walker_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic        req_user = 1'b0;
    logic        pg_enable = 1'b0;
    logic [31:0] dir_base = 32'h7A5C_2000;
    logic        resp_valid;
    logic [31:0] resp_paddr;
    logic        resp_fault;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;

    always #2 clk = ~clk;

    pt_walker dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .req_write(req_write), .req_user(req_user), .pg_enable(pg_enable),
        .dir_base(dir_base),
        .resp_valid(resp_valid), .resp_paddr(resp_paddr), .resp_fault(resp_fault),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    int tests = 0;
    int fails = 0;
    bit done = 0;

    logic [31:0] mem [4096];
    int          lat = 0;
    int          wait_c = 0;
    int          n_rd = 0, n_wr = 0, resp_cnt = 0;
    logic [31:0] rd_a0 = '0, rd_a1 = '0, wr_a = '0, wr_d = '0;

    // Memory responder: one access in flight, programmable latency
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
            wait_c = 0;
        end else if (mem_ack) begin
            mem_ack <= 1'b0;
            wait_c = 0;
        end else if (mem_req) begin
            if (wait_c >= lat) begin
                mem_ack <= 1'b1;
                if (mem_we) begin
                    mem[mem_addr[13:2]] = mem_wdata;
                    wr_a = mem_addr;
                    wr_d = mem_wdata;
                    n_wr++;
                end else begin
                    mem_rdata <= mem[mem_addr[13:2]];
                    if (n_rd == 0) rd_a0 = mem_addr; else rd_a1 = mem_addr;
                    n_rd++;
                end
            end else begin
                wait_c++;
            end
        end
    end

    always @(posedge clk) begin
        if (resp_valid) resp_cnt++;
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit ent_ok(input logic [31:0] e, input bit wr, input bit usr);
        return e[0] && !(usr && !e[2]) && !(wr && !e[1]);
    endfunction

    task automatic walk(input logic [31:0] va, input bit wr, input bit usr, input bit pg);
        bit          e_flt = 0, e_wb = 0, got = 0;
        logic [31:0] e_pa = '0, e_a0 = '0, e_a1 = '0, e_wa = '0, e_wd = '0, leaf, la, pde, pte;
        int          e_rd = 0, cyc = 0;
        // expected result from the requirement text
        if (pg) begin
            e_a0 = {dir_base[31:12], va[31:22], 2'b00};
            pde = mem[e_a0[13:2]];
            e_rd = 1;
            if (!ent_ok(pde, wr, usr)) e_flt = 1;
            else begin
                if (pde[7]) begin
                    leaf = pde; la = e_a0; e_pa = {pde[31:22], va[21:0]};
                end else begin
                    e_a1 = {pde[31:12], va[21:12], 2'b00};
                    pte = mem[e_a1[13:2]];
                    e_rd = 2;
                    leaf = pte; la = e_a1; e_pa = {pte[31:12], va[11:0]};
                    if (!ent_ok(pte, wr, usr)) begin e_flt = 1; e_pa = '0; end
                end
                if (!e_flt && (!leaf[3] || (wr && !leaf[4]))) begin
                    e_wb = 1; e_wa = la; e_wd = leaf | 32'h8 | (wr ? 32'h10 : 32'h0);
                end
            end
        end else begin
            e_pa = va;
        end

        @(negedge clk);
        n_rd = 0; n_wr = 0; resp_cnt = 0;
        req_vaddr = va; req_write = wr; req_user = usr; pg_enable = pg; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        if (!pg) begin
            // R1: answer appears in the cycle right after acceptance
            check(resp_valid === 1'b1, "R1 bypass latency", {31'b0, resp_valid}, 32'h1);
        end
        while (!resp_valid && cyc < 100) begin
            @(negedge clk);
            cyc++;
        end
        got = resp_valid;
        check(got, "R11 response seen", {31'b0, got}, 32'h1);
        check(resp_fault === e_flt, "R5/R6/R7 fault flag", {31'b0, resp_fault}, {31'b0, e_flt});
        check(resp_paddr === e_pa, pg ? "R3/R4 physical address" : "R1 physical address", resp_paddr, e_pa);
        @(negedge clk);
        @(negedge clk);
        check(resp_cnt == 1, "R11 single pulse", resp_cnt, 1);
        check(n_rd == e_rd, "R9 read count (R3 R4 R1)", n_rd, e_rd);
        if (e_rd >= 1) check(rd_a0 === e_a0, "R2 directory address", rd_a0, e_a0);
        if (e_rd == 2) check(rd_a1 === e_a1, "R2 table address", rd_a1, e_a1);
        check(n_wr == int'(e_wb), "R8 write-back count", n_wr, int'(e_wb));
        if (e_wb) begin
            check(wr_a === e_wa, "R8 write-back address", wr_a, e_wa);
            check(wr_d === e_wd, "R8 write-back data", wr_d, e_wd);
        end
    endtask

    initial begin
        #800000;
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4096; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        check(req_ready === 1'b1, "R12 ready after reset", {31'b0, req_ready}, 32'h1);
        check(mem_req === 1'b0, "R12 no memory request", {31'b0, mem_req}, 32'h0);
        check(resp_valid === 1'b0, "R12 no response", {31'b0, resp_valid}, 32'h0);

        // R1: paging off pass-through
        walk(32'h0000_0000, 0, 0, 0);
        walk(32'hDEAD_BEEF, 1, 1, 0);
        walk(32'h8040_1FFC, 0, 1, 0);

        // R3 R5 R6 R7 R8: normal pages, all permission/access combinations
        for (int f1 = 0; f1 < 8; f1++) begin
            for (int f2 = 0; f2 < 8; f2++) begin
                for (int ad = 0; ad < 4; ad++) begin
                    for (int op = 0; op < 4; op++) begin
                        lat = (f1 + f2 + ad + op) % 4;
                        mem[2048 + 1] = 32'h3B10_1000 | f1;
                        mem[1024 + 5] = 32'hABCD_E000 | f2 | (ad << 3);
                        walk({10'd1, 10'd5, 12'h9A4 + 12'(op)}, op[0], op[1], 1);
                    end
                end
            end
        end

        // R4: large pages with permission and access combinations
        for (int f1 = 0; f1 < 8; f1++) begin
            for (int ad = 0; ad < 4; ad++) begin
                for (int op = 0; op < 4; op++) begin
                    lat = (f1 + ad) % 3;
                    mem[2048 + 2] = 32'h4B00_0000 | 32'h80 | f1 | (ad << 3);
                    walk({10'd2, 22'h2A_5F31 + 22'(op)}, op[0], op[1], 1);
                end
            end
        end

        // R10: request held high while busy is ignored
        lat = 2;
        mem[2048 + 3] = 32'h3B10_1000 | 32'h7;
        mem[1024 + 7] = 32'h1234_5000 | 32'h1F;
        @(negedge clk);
        n_rd = 0; n_wr = 0; resp_cnt = 0;
        req_vaddr = {10'd3, 10'd7, 12'h0AB}; req_write = 0; req_user = 0; pg_enable = 1; req_valid = 1'b1;
        @(negedge clk);
        req_vaddr = 32'hFFFF_FFFF;
        while (!resp_valid) @(negedge clk);
        check(resp_paddr === 32'h1234_50AB, "R10 result of first request", resp_paddr, 32'h1234_50AB);
        req_valid = 1'b0;
        repeat (6) @(negedge clk);
        check(resp_cnt == 1, "R10 busy request ignored", resp_cnt, 1);
        check(n_rd == 2, "R10 no extra reads", n_rd, 2);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule